// File: doc/BRIEF.md
# Partitioned Frequency-Domain Convolution Accumulator

This block is the spectral core of a uniformly partitioned fast convolution. A long filter is cut into `P_PARTS` equal segments, and each segment is stored as a complex spectrum of `L_BINS` bins in an internal coefficient store. The store is filled through a simple write port. The forward and inverse transforms sit outside the block. For every input spectrum, bin by bin, the block multiplies the bin by every segment spectrum and adds each rounded complex product into one of `P_PARTS` spectral accumulators. When the last bin of a block has been processed, the oldest accumulator is streamed out towards the inverse transform and is cleared as it goes. The remaining accumulators then move up one place in age. This is done by advancing a base pointer over the physical banks, so no data is copied.

A small state machine sequences the work. It has three states. In `S_ACCEPT` the block waits for an input bin. In `S_MAC` it spends one cycle per partition with one shared complex multiplier. In `S_RELEASE` it emits the oldest accumulator. The transitions are:
- `T_TAKE`: S_ACCEPT to S_MAC, when a bin is accepted.
- `T_NEXT_BIN`: S_MAC to S_ACCEPT, after the last partition of a bin that is not the final bin.
- `T_BLOCK_END`: S_MAC to S_RELEASE, after the last partition of the final bin.
- `T_RELEASE_END`: S_RELEASE to S_ACCEPT, after the final output bin. The base pointer advances here.
- `T_RELOAD`: any state to S_ACCEPT, on a coefficient write.

Each input block therefore costs `L_BINS*P_PARTS` multiply-accumulate cycles plus `L_BINS` release cycles.

Top module: `pfa_accum`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0, and all accumulators hold zero.
- R2: The output spectrum of block m at bin k equals the sum over i = 0..P_PARTS-1 of rnd(X[m-i][k]·S[i][k]). Here S[i] is the spectrum of segment i, and blocks before the first block (or before the latest reload) count as zero. Accumulator width is DW+2+clog2(P_PARTS), so the sum never wraps.
- R3: Bins and coefficients are signed two's complement, DW bits wide. The real product is ar·br−ai·bi and the imaginary product is ar·bi+ai·br. rnd(p) = (p + 2^(DW−2)) arithmetically shifted right by DW−1.
- R4: A bin is taken at a rising edge where `in_valid` and `in_ready` are both 1. After each taken bin, `in_ready` is 0 for exactly P_PARTS cycles.
- R5: `in_valid` and the input data are ignored while `in_ready` is 0.
- R6: Exactly P_PARTS cycles after the final bin of a block is taken, `out_valid` rises. It stays high for exactly L_BINS consecutive cycles and carries bins 0 to L_BINS−1 in order. `in_ready` is 0 during this window and returns to 1 in the following cycle.
- R7: `out_last` is 1 only together with output bin L_BINS−1.
- R8: Results stay correct over more than P_PARTS blocks, including when the base pointer wraps with a partition count that is not a power of two.
- R9: A cycle with `coef_we` = 1 stores the coefficient at (`coef_part`, `coef_bin`). It also clears every accumulator, the base pointer and any partial block, and the next cycle is in S_ACCEPT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| coef_we | input | 1 | Coefficient write strobe; also clears accumulation state |
| coef_part | input | clog2(P_PARTS) | Segment index of the coefficient |
| coef_bin | input | clog2(L_BINS) | Bin index of the coefficient |
| coef_re | input | DW | Coefficient real part |
| coef_im | input | DW | Coefficient imaginary part |
| in_valid | input | 1 | Input bin present |
| in_ready | output | 1 | Block can accept an input bin |
| in_re | input | DW | Input bin real part |
| in_im | input | DW | Input bin imaginary part |
| out_valid | output | 1 | Output bin present |
| out_last | output | 1 | Final bin of an output spectrum |
| out_re | output | DW+2+clog2(P_PARTS) | Output bin real part |
| out_im | output | DW+2+clog2(P_PARTS) | Output bin imaginary part |

## Verification
The bench builds the block with P_PARTS = 3, L_BINS = 4 and DW = 8. With these values every bin of every block, and every stall and release window, can be checked one by one against a model computed in the bench. Using three partitions makes the base pointer wrap around a ring whose size is not a power of two. The 8-bit width lets a run of all −128 operands reach the largest rounded product and the largest accumulated sum. A reload in the middle of a block and input bins offered during stalls are both covered within a few hundred cycles.

// File: rtl/pfa_pkg.sv
package pfa_pkg;

    typedef enum logic [1:0] {
        S_ACCEPT  = 2'd0,
        S_MAC     = 2'd1,
        S_RELEASE = 2'd2
    } pfa_state_e;

endpackage

// File: rtl/pfa_cmul.sv
// Complex multiply with a single rounding step, fixed-point Q(DW-1) operands.
module pfa_cmul #(
    parameter int DW = 16,
    parameter int RW = DW + 2
) (
    input  logic signed [DW-1:0] a_re,
    input  logic signed [DW-1:0] a_im,
    input  logic signed [DW-1:0] b_re,
    input  logic signed [DW-1:0] b_im,
    output logic signed [RW-1:0] p_re,
    output logic signed [RW-1:0] p_im
);
    localparam int FRAC = DW - 1;
    localparam int MW   = 2 * DW + 1;
    localparam logic signed [MW-1:0] HALF = MW'(1) << (FRAC - 1);

    logic signed [MW-1:0] rr, ii, ri, ir;
    logic signed [MW-1:0] full_re, full_im;

    always_comb begin
        rr      = MW'(a_re) * MW'(b_re);
        ii      = MW'(a_im) * MW'(b_im);
        ri      = MW'(a_re) * MW'(b_im);
        ir      = MW'(a_im) * MW'(b_re);
        full_re = rr - ii;
        full_im = ri + ir;
        p_re    = RW'((full_re + HALF) >>> FRAC);
        p_im    = RW'((full_im + HALF) >>> FRAC);
    end
endmodule

// File: rtl/pfa_coef_ram.sv
// Segment spectra storage: one write port, one combinational read port.
module pfa_coef_ram #(
    parameter int P_PARTS = 4,
    parameter int L_BINS  = 16,
    parameter int DW      = 16,
    parameter int PW      = 2,
    parameter int BW      = 4
) (
    input  logic                 clk,
    input  logic                 we,
    input  logic [PW-1:0]        w_part,
    input  logic [BW-1:0]        w_bin,
    input  logic signed [DW-1:0] w_re,
    input  logic signed [DW-1:0] w_im,
    input  logic [PW-1:0]        r_part,
    input  logic [BW-1:0]        r_bin,
    output logic signed [DW-1:0] r_re,
    output logic signed [DW-1:0] r_im
);
    logic signed [DW-1:0] mem_re [P_PARTS][L_BINS];
    logic signed [DW-1:0] mem_im [P_PARTS][L_BINS];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_re[w_part][w_bin] <= w_re;
            mem_im[w_part][w_bin] <= w_im;
        end
    end

    always_comb begin
        r_re = mem_re[r_part][r_bin];
        r_im = mem_im[r_part][r_bin];
    end
endmodule

// File: rtl/pfa_acc_bank.sv
// Ring of spectral accumulator banks; one bank per partition.
module pfa_acc_bank #(
    parameter int P_PARTS = 4,
    parameter int L_BINS  = 16,
    parameter int AW      = 20,
    parameter int PW      = 2,
    parameter int BW      = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr_all,
    input  logic                 we,
    input  logic [PW-1:0]        bank,
    input  logic [BW-1:0]        bin,
    input  logic signed [AW-1:0] w_re,
    input  logic signed [AW-1:0] w_im,
    output logic signed [AW-1:0] r_re,
    output logic signed [AW-1:0] r_im
);
    logic signed [AW-1:0] word_re [P_PARTS];
    logic signed [AW-1:0] word_im [P_PARTS];

    for (genvar g = 0; g < P_PARTS; g++) begin : g_bank
        logic signed [AW-1:0] re_q [L_BINS];
        logic signed [AW-1:0] im_q [L_BINS];

        always_ff @(posedge clk) begin
            if (rst || clr_all) begin
                for (int i = 0; i < L_BINS; i++) begin
                    re_q[i] <= '0;
                    im_q[i] <= '0;
                end
            end else if (we && bank == PW'(g)) begin
                re_q[bin] <= w_re;
                im_q[bin] <= w_im;
            end
        end

        assign word_re[g] = re_q[bin];
        assign word_im[g] = im_q[bin];
    end

    always_comb begin
        r_re = word_re[bank];
        r_im = word_im[bank];
    end
endmodule

// File: rtl/pfa_ctrl.sv
// Sequencer: bin acceptance, per-partition MAC steps, release of the oldest bank.
module pfa_ctrl
    import pfa_pkg::*;
#(
    parameter int P_PARTS = 4,
    parameter int L_BINS  = 16,
    parameter int PW      = 2,
    parameter int BW      = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reload,
    input  logic          in_valid,
    output logic          in_ready,
    output logic          x_take,
    output logic          mac_en,
    output logic          rel_en,
    output logic          out_valid,
    output logic          out_last,
    output logic [PW-1:0] part,
    output logic [BW-1:0] bin,
    output logic [PW-1:0] bank
);
    pfa_state_e    state_q, state_d;
    logic [PW-1:0] part_q, base_q;
    logic [BW-1:0] bin_q;
    logic          last_part, last_bin;
    logic [PW:0]   ring_sum;

    assign last_part = (part_q == PW'(P_PARTS - 1));
    assign last_bin  = (bin_q  == BW'(L_BINS - 1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (reload) begin
            state_d = S_ACCEPT;                       // T_RELOAD
        end else begin
            unique case (state_q)
                S_ACCEPT:  if (in_valid) state_d = S_MAC;  // T_TAKE
                S_MAC:     if (last_part) state_d = last_bin ? S_RELEASE   // T_BLOCK_END
                                                             : S_ACCEPT;   // T_NEXT_BIN
                S_RELEASE: if (last_bin) state_d = S_ACCEPT;               // T_RELEASE_END
                default:   state_d = S_ACCEPT;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= S_ACCEPT;
        else     state_q <= state_d;
    end

    // counters and ring pointer
    always_ff @(posedge clk) begin
        if (rst || reload) begin
            part_q <= '0;
            bin_q  <= '0;
            base_q <= '0;
        end else begin
            unique case (state_q)
                S_ACCEPT: if (in_valid) part_q <= '0;
                S_MAC: begin
                    if (last_part) begin
                        part_q <= '0;
                        bin_q  <= last_bin ? '0 : bin_q + 1'b1;
                    end else begin
                        part_q <= part_q + 1'b1;
                    end
                end
                S_RELEASE: begin
                    if (last_bin) begin
                        bin_q  <= '0;
                        base_q <= (base_q == PW'(P_PARTS - 1)) ? '0 : base_q + 1'b1;
                    end else begin
                        bin_q <= bin_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        ring_sum  = {1'b0, base_q} + {1'b0, part_q};
        in_ready  = (state_q == S_ACCEPT);
        out_valid = (state_q == S_RELEASE);
        out_last  = out_valid && last_bin;
        x_take    = in_ready && in_valid && !reload;
        mac_en    = (state_q == S_MAC) && !reload;
        rel_en    = out_valid && !reload;
        part      = part_q;
        bin       = bin_q;
        if (out_valid)
            bank = base_q;
        else if (ring_sum >= (PW+1)'(P_PARTS))
            bank = PW'(ring_sum - (PW+1)'(P_PARTS));
        else
            bank = PW'(ring_sum);
    end
endmodule

// File: rtl/pfa_accum.sv
module pfa_accum #(
    parameter int P_PARTS = 4,
    parameter int L_BINS  = 16,
    parameter int DW      = 16,
    localparam int PW     = (P_PARTS > 1) ? $clog2(P_PARTS) : 1,
    localparam int BW     = (L_BINS > 1) ? $clog2(L_BINS) : 1,
    localparam int AW     = DW + 2 + PW
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 coef_we,
    input  logic [PW-1:0]        coef_part,
    input  logic [BW-1:0]        coef_bin,
    input  logic signed [DW-1:0] coef_re,
    input  logic signed [DW-1:0] coef_im,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic signed [DW-1:0] in_re,
    input  logic signed [DW-1:0] in_im,
    output logic                 out_valid,
    output logic                 out_last,
    output logic signed [AW-1:0] out_re,
    output logic signed [AW-1:0] out_im
);
    localparam int RW = DW + 2;

    logic                 x_take, mac_en, rel_en;
    logic [PW-1:0]        part, bank;
    logic [BW-1:0]        bin;
    logic signed [DW-1:0] x_re_q, x_im_q, s_re, s_im;
    logic signed [RW-1:0] p_re, p_im;
    logic signed [AW-1:0] a_re, a_im, w_re, w_im;

    pfa_ctrl #(.P_PARTS(P_PARTS), .L_BINS(L_BINS), .PW(PW), .BW(BW)) u_ctrl (
        .clk(clk), .rst(rst), .reload(coef_we), .in_valid(in_valid),
        .in_ready(in_ready), .x_take(x_take), .mac_en(mac_en), .rel_en(rel_en),
        .out_valid(out_valid), .out_last(out_last),
        .part(part), .bin(bin), .bank(bank)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            x_re_q <= '0;
            x_im_q <= '0;
        end else if (x_take) begin
            x_re_q <= in_re;
            x_im_q <= in_im;
        end
    end

    pfa_coef_ram #(.P_PARTS(P_PARTS), .L_BINS(L_BINS), .DW(DW), .PW(PW), .BW(BW)) u_coef (
        .clk(clk), .we(coef_we), .w_part(coef_part), .w_bin(coef_bin),
        .w_re(coef_re), .w_im(coef_im), .r_part(part), .r_bin(bin),
        .r_re(s_re), .r_im(s_im)
    );

    pfa_cmul #(.DW(DW), .RW(RW)) u_mul (
        .a_re(x_re_q), .a_im(x_im_q), .b_re(s_re), .b_im(s_im),
        .p_re(p_re), .p_im(p_im)
    );

    always_comb begin
        if (rel_en) begin
            w_re = '0;
            w_im = '0;
        end else begin
            w_re = a_re + AW'(p_re);
            w_im = a_im + AW'(p_im);
        end
    end

    pfa_acc_bank #(.P_PARTS(P_PARTS), .L_BINS(L_BINS), .AW(AW), .PW(PW), .BW(BW)) u_acc (
        .clk(clk), .rst(rst), .clr_all(coef_we), .we(mac_en || rel_en),
        .bank(bank), .bin(bin), .w_re(w_re), .w_im(w_im),
        .r_re(a_re), .r_im(a_im)
    );

    assign out_re = a_re;
    assign out_im = a_im;
endmodule

// File: rtl/pfa_accum_chk.sv
module pfa_accum_chk (
    input logic clk,
    input logic rst,
    input logic coef_we,
    input logic in_valid,
    input logic in_ready,
    input logic out_valid,
    input logic out_last
);
    // R4
    take_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && !coef_we) |=> !in_ready);

    // R6
    ready_release_excl_chk: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> !out_valid);

    // R7
    last_in_window_chk: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid);

    // R6
    release_close_chk: assert property (@(posedge clk) disable iff (rst)
        (out_last && !coef_we) |=> (in_ready && !out_valid));

    // R9
    reload_idle_chk: assert property (@(posedge clk) disable iff (rst)
        coef_we |=> (in_ready && !out_valid));
endmodule

bind pfa_accum pfa_accum_chk u_chk (
    .clk(clk), .rst(rst), .coef_we(coef_we), .in_valid(in_valid),
    .in_ready(in_ready), .out_valid(out_valid), .out_last(out_last)
);

// File: tb/pfa_accum_tb.sv
module pfa_accum_tb_top;
    localparam int P  = 3;
    localparam int L  = 4;
    localparam int DW = 8;
    localparam int PW = 2;
    localparam int BW = 2;
    localparam int AW = DW + 2 + PW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic coef_we = 1'b0;
    logic [PW-1:0] coef_part = '0;
    logic [BW-1:0] coef_bin = '0;
    logic signed [DW-1:0] coef_re = '0, coef_im = '0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic signed [DW-1:0] in_re = '0, in_im = '0;
    logic out_valid, out_last;
    logic signed [AW-1:0] out_re, out_im;

    always #2 clk = ~clk;

    pfa_accum #(.P_PARTS(P), .L_BINS(L), .DW(DW)) dut_i (
        .clk(clk), .rst(rst), .coef_we(coef_we), .coef_part(coef_part),
        .coef_bin(coef_bin), .coef_re(coef_re), .coef_im(coef_im),
        .in_valid(in_valid), .in_ready(in_ready), .in_re(in_re), .in_im(in_im),
        .out_valid(out_valid), .out_last(out_last), .out_re(out_re), .out_im(out_im)
    );

    int checks = 0, fails = 0;
    bit finished = 0;
    int s_re [P][L], s_im [P][L];
    int h_re [P][L], h_im [P][L];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int rnd(input int p);
        return (p + (1 << (DW - 2))) >>> (DW - 1);
    endfunction

    function automatic int expect_bin(input int k, input bit im);
        int s = 0;
        for (int i = 0; i < P; i++) begin
            if (im) s += rnd(h_re[i][k] * s_im[i][k] + h_im[i][k] * s_re[i][k]);
            else    s += rnd(h_re[i][k] * s_re[i][k] - h_im[i][k] * s_im[i][k]);
        end
        return s;
    endfunction

    function automatic int xval(input int m, input int k, input int pat, input bit im);
        if (pat == 1) return -128;
        if (pat == 2) return 127;
        return ((m * 53 + k * 29 + (im ? 17 : 7)) % 256) - 128;
    endfunction

    // R9: load all coefficients, which also clears accumulation state
    task automatic load_coefs(input int mode);
        for (int p = 0; p < P; p++) begin
            for (int k = 0; k < L; k++) begin
                if (mode == 2) begin
                    s_re[p][k] = -128; s_im[p][k] = -128;
                end else if (mode == 1) begin
                    s_re[p][k] = ((p * 19 + k * 101 + 200) % 256) - 128;
                    s_im[p][k] = ((p * 19 + k * 101 + 33) % 256) - 128;
                end else begin
                    s_re[p][k] = ((p * 71 + k * 13 + 90) % 256) - 128;
                    s_im[p][k] = ((p * 71 + k * 13 + 5) % 256) - 128;
                end
                @(negedge clk);
                coef_we = 1'b1; coef_part = PW'(p); coef_bin = BW'(k);
                coef_re = DW'(s_re[p][k]); coef_im = DW'(s_im[p][k]);
            end
        end
        @(negedge clk);
        coef_we = 1'b0;
        for (int i = 0; i < P; i++)
            for (int k = 0; k < L; k++) begin
                h_re[i][k] = 0; h_im[i][k] = 0;
            end
        chk(in_ready == 1'b1 && out_valid == 1'b0, "R9 idle after reload", int'(in_ready), 1);
    endtask

    // Called at a negedge with in_ready high. Returns at the negedge after the stall.
    task automatic send_bin(input int xr, input int xi, input bit junk, input bit last);
        int st = 0;
        in_valid = 1'b1; in_re = DW'(xr); in_im = DW'(xi);
        @(negedge clk);
        while (!in_ready && !out_valid) begin
            st++;
            in_valid = junk;
            in_re = DW'(st * 37 + 11); in_im = DW'(st * 91 + 3);
            @(negedge clk);
        end
        in_valid = 1'b0;
        chk(st == P, "R4 stall length", st, P);
        if (last) chk(out_valid == 1'b1, "R6 release follows final bin", int'(out_valid), 1);
        else      chk(in_ready == 1'b1, "R4 ready after stall", int'(in_ready), 1);
    endtask

    task automatic run_block(input int m, input int pat, input bit junk);
        for (int i = P - 1; i > 0; i--)
            for (int k = 0; k < L; k++) begin
                h_re[i][k] = h_re[i-1][k]; h_im[i][k] = h_im[i-1][k];
            end
        for (int k = 0; k < L; k++) begin
            h_re[0][k] = xval(m, k, pat, 0);
            h_im[0][k] = xval(m, k, pat, 1);
        end
        for (int k = 0; k < L; k++)
            send_bin(h_re[0][k], h_im[0][k], junk, k == L - 1);
        for (int k = 0; k < L; k++) begin
            chk(out_valid == 1'b1 && in_ready == 1'b0, "R6 release window", int'(out_valid), 1);
            chk(int'(out_re) == expect_bin(k, 0), "R2 R8 output real", int'(out_re), expect_bin(k, 0));
            chk(int'(out_im) == expect_bin(k, 1), "R2 R8 output imag", int'(out_im), expect_bin(k, 1));
            chk(out_last == (k == L - 1), "R7 last flag", int'(out_last), int'(k == L - 1));
            @(negedge clk);
        end
        chk(out_valid == 1'b0 && in_ready == 1'b1, "R6 window closes", int'(out_valid), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1
        chk(in_ready == 1'b1 && out_valid == 1'b0, "R1 reset state", int'(out_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(in_ready == 1'b1 && out_valid == 1'b0, "R1 after reset", int'(in_ready), 1);

        load_coefs(0);
        for (int m = 0; m < 2 * P + 2; m++)
            run_block(m, 0, (m % 2) == 1);   // R5 junk offered during stalls on odd blocks

        // R9: reload after a partial block discards it and all sums
        run_block(20, 0, 0);
        send_bin(55, -40, 1, 0);
        send_bin(-99, 12, 0, 0);
        load_coefs(1);
        for (int m = 30; m < 30 + P + 2; m++)
            run_block(m, 0, 1);

        // R3 R2 boundary: extreme operands in every slot
        load_coefs(2);
        for (int m = 0; m < P + 1; m++)
            run_block(m, 1, 0);
        run_block(0, 2, 0);
        chk(expect_bin(0, 1) == 2 * 256 + rnd(-2 * 127 * 128), "R3 model sanity", expect_bin(0, 1),
            2 * 256 + rnd(-2 * 127 * 128));

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule